// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block conditions the active-low external reset pin before it may request a system reset. The pin is first brought into the bus clock domain by a short synchronizer chain. After that, a mode-dependent filter decides when a new pin level is accepted. There are two filters:

- a bus-clock filter whose length is programmable from 1 to 32 cycles;
- a slow filter that advances only on a low-power clock tick and needs a fixed 3 ticks.

In run and wait modes a 2-bit select chooses no filter, the bus-clock filter or the slow filter. In stop modes a 1-bit select chooses between no filter and the slow filter.

A byte-wide register port holds the two configuration registers. Only the power-on reset returns them to zero. The output `pin_rst_req` is high while the accepted pin level is low, and the reset controller uses it as the pin-reset request.

Each filter throws away its partial count whenever it is not the one selected. The slow filter also restarts when the chip enters a low-leakage stop mode. This means a half-seen pulse can never complete under a different configuration.

Top module: `rpf_top`

## Requirements
- R1: After power-on reset, both configuration registers read 0x00 and `pin_rst_req` is low while the pin is high.
- R2: The mode register is at offset 0x4. Its bits [1:0] are the run/wait select and bit 2 is the stop select. The count register is at offset 0x5, with its value in bits [4:0]. Reserved bits ignore writes and read as zero, and every other offset reads 0x00.
- R3: With run/wait select 00 or 11 and stop mode low, `pin_rst_req` equals the inverted pin. It follows the pin at the second rising clock edge after the pin changes.
- R4: With run/wait select 01 and stop mode low, a pin change reaches `pin_rst_req` at rising edge number count+3 after the change, where count is the value in bits [4:0] of the count register. This covers the two synchronizer edges plus count+1 agreeing filter clocks.
- R5: A pin level held for fewer filter clocks than the filter length is discarded. Any opposite sample restarts the count, so the output does not change.
- R6: With run/wait select 10 and stop mode low, the accepted level changes only after 3 consecutive `lp_tick` cycles that sample the new synchronized level. Cycles without a tick change nothing.
- R7: With stop mode high, the bus-clock filter is never used. Stop select 0 passes the synchronized pin straight through, and stop select 1 uses the 3-tick slow filter.
- R8: The bus-clock filter is cleared while it is not selected. After it is selected again, it needs the full count+1 new clocks before `pin_rst_req` rises.
- R9: The slow filter is cleared while it is not selected and in the cycle `lls_mode` rises. Ticks counted before that cycle do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Active-low power-on reset |
| pin_n | input | 1 | Raw active-low external reset pin |
| lp_tick | input | 1 | One-cycle enable marking a low-power clock period |
| stop_mode | input | 1 | High while the chip is in a stop mode |
| lls_mode | input | 1 | High while in a low-leakage stop mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_rst_req | output | 1 | Filtered pin-reset request, active high |

## Verification
A filter count that is wrong inside the block shows up at `pin_rst_req` as an edge that comes one or more clocks early or late. The bench therefore checks both the cycle just before the expected edge and the cycle of the edge itself.

A filter that fails to clear carries a stale level or count into the next configuration. That error appears as an immediate or early request right after a mode write or a low-leakage entry, within the filter length.

Register faults appear on the very next read.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    localparam int REG_AW     = 3;
    localparam int REG_DW     = 8;
    localparam int MODE_OFS   = 4;
    localparam int COUNT_OFS  = 5;
    localparam int MODE_BITS  = 3;
    localparam int COUNT_BITS = 5;

    localparam logic [REG_DW-1:0] MODE_MASK  = REG_DW'((1 << MODE_BITS) - 1);
    localparam logic [REG_DW-1:0] COUNT_MASK = REG_DW'((1 << COUNT_BITS) - 1);

    typedef struct packed {
        logic       stop_sel;
        logic [1:0] run_sel;
    } mode_t;

    typedef enum logic [1:0] {
        FSEL_NONE = 2'd0,
        FSEL_BUS  = 2'd1,
        FSEL_LP   = 2'd2
    } fsel_e;

    function automatic fsel_e pick_filter(input mode_t m, input logic in_stop);
        fsel_e f;
        if (in_stop) begin
            f = m.stop_sel ? FSEL_LP : FSEL_NONE;
        end else begin
            case (m.run_sel)
                2'b01:   f = FSEL_BUS;
                2'b10:   f = FSEL_LP;
                default: f = FSEL_NONE;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    assign stg_d[0] = d_i;
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_chain
            assign stg_d[i] = stg_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];

    // R3: the last stage carries the value held by the stage before it one clock earlier
    a_r3_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[STAGES-2] |=> stg_q[STAGES-1]);

endmodule

// File: rtl/rpf_level_filter.sv
module rpf_level_filter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic             din_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } fstate_t;

    fstate_t st_d, st_q;
    logic    reached;

    always_comb begin
        st_d    = st_q;
        reached = ({1'b0, st_q.cnt} + 1'b1) >= {1'b0, limit_i};
        if (clr_i) begin
            st_d.level = 1'b1;
            st_d.cnt   = '0;
        end else if (step_i) begin
            if (din_i == st_q.level) begin
                st_d.cnt = '0;
            end else if (reached) begin
                st_d.level = din_i;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    // R5: an agreeing sample never flips the accepted level
    a_r5_agree_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && din_i == st_q.level) |=> $stable(st_q.level));

    // R6: without a step or clear the accepted level is frozen
    a_r6_no_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(st_q.level));

    // R8: a clear leaves the filter idle
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.level && st_q.cnt == '0));

endmodule

// File: rtl/rpf_regs.sv
module rpf_regs
    import rpf_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [REG_DW-1:0] rdata_o,
    output mode_t             mode_o,
    output logic [COUNT_BITS-1:0] count_o
);
    typedef struct packed {
        logic [REG_DW-1:0] mode;
        logic [REG_DW-1:0] count;
    } rstate_t;

    rstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == REG_AW'(MODE_OFS))  st_d.mode  = wdata_i & MODE_MASK;
        if (wr_i && addr_i == REG_AW'(COUNT_OFS)) st_d.count = wdata_i & COUNT_MASK;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            REG_AW'(MODE_OFS):  rdata_o = st_q.mode;
            REG_AW'(COUNT_OFS): rdata_o = st_q.count;
            default:            rdata_o = '0;
        endcase
    end

    assign mode_o  = mode_t'(st_q.mode[MODE_BITS-1:0]);
    assign count_o = st_q.count[COUNT_BITS-1:0];

    // R2: a mode write lands in the select fields on the next clock
    a_r2_mode_write: assert property (@(posedge clk) disable iff (!por_n)
        (wr_i && addr_i == REG_AW'(MODE_OFS)) |=> (mode_o == mode_t'($past(wdata_i[MODE_BITS-1:0]))));

endmodule

// File: rtl/rpf_top.sv
module rpf_top
    import rpf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LP_COUNT    = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pin_n,
    input  logic              lp_tick,
    input  logic              stop_mode,
    input  logic              lls_mode,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              pin_rst_req
);
    localparam int CNT_W = COUNT_BITS + 1;

    typedef struct packed {
        logic lls;
    } tstate_t;

    tstate_t                 st_d, st_q;
    mode_t                   mode;
    logic [COUNT_BITS-1:0]   count;
    logic                    pin_sync;
    fsel_e                   fsel;
    logic                    bus_clr, lp_clr;
    logic [CNT_W-1:0]        bus_limit;
    logic                    bus_level, lp_level;

    rpf_regs u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .mode_o  (mode),
        .count_o (count)
    );

    rpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (pin_n),
        .q_o   (pin_sync)
    );

    always_comb begin
        st_d.lls  = lls_mode;
        fsel      = pick_filter(mode, stop_mode);
        bus_clr   = (fsel != FSEL_BUS);
        lp_clr    = (fsel != FSEL_LP) || (lls_mode && !st_q.lls);
        bus_limit = {1'b0, count} + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rpf_level_filter #(.CNT_W(CNT_W)) u_bus_filt (
        .clk     (clk),
        .rst_n   (por_n),
        .step_i  (1'b1),
        .clr_i   (bus_clr),
        .din_i   (pin_sync),
        .limit_i (bus_limit),
        .level_o (bus_level)
    );

    rpf_level_filter #(.CNT_W(CNT_W)) u_lp_filt (
        .clk     (clk),
        .rst_n   (por_n),
        .step_i  (lp_tick),
        .clr_i   (lp_clr),
        .din_i   (pin_sync),
        .limit_i (CNT_W'(LP_COUNT)),
        .level_o (lp_level)
    );

    always_comb begin
        case (fsel)
            FSEL_BUS: pin_rst_req = ~bus_level;
            FSEL_LP:  pin_rst_req = ~lp_level;
            default:  pin_rst_req = ~pin_sync;
        endcase
    end

    // R7: in stop mode the bus-clock filter sits idle
    a_r7_bus_idle_in_stop: assert property (@(posedge clk) disable iff (!por_n)
        stop_mode |=> bus_level);

    // R9: entering low-leakage stop leaves the slow filter idle
    a_r9_lls_entry_clears: assert property (@(posedge clk) disable iff (!por_n)
        (lls_mode && !st_q.lls) |=> lp_level);

endmodule

// File: tb/rpf_top_bench.sv
module rpf_top_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       lp_tick = 1'b0;
    logic       stop_mode = 1'b0;
    logic       lls_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pin_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpf_top u_rpf_top (
        .clk         (clk),
        .por_n       (por_n),
        .pin_n       (pin_n),
        .lp_tick     (lp_tick),
        .stop_mode   (stop_mode),
        .lls_mode    (lls_mode),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pin_rst_req (pin_rst_req)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, tag);
    endtask

    task automatic tick();
        lp_tick = 1'b1;
        @(negedge clk);
        lp_tick = 1'b0;
    endtask

    task automatic go_idle();
        wr(3'd4, 8'h00);
        stop_mode = 1'b0; lls_mode = 1'b0; pin_n = 1'b1; lp_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rd_check(3'd4, 0, "R1 mode reg after POR");
        rd_check(3'd5, 0, "R1 count reg after POR");
        check(pin_rst_req, 0, "R1 request low after POR");
    endtask

    task automatic t_reg_map();
        wr(3'd4, 8'hFF);
        rd_check(3'd4, 8'h07, "R2 mode reserved bits");
        wr(3'd5, 8'hFF);
        rd_check(3'd5, 8'h1F, "R2 count reserved bits");
        rd_check(3'd0, 0, "R2 unmapped offset 0");
        rd_check(3'd6, 0, "R2 unmapped offset 6");
        wr(3'd5, 8'h00);
        rd_check(3'd5, 0, "R2 count rewrite");
    endtask

    task automatic t_passthrough(input logic [7:0] code, input string tag);
        go_idle();
        wr(3'd4, code);
        pin_n = 1'b0;
        @(negedge clk);
        check(pin_rst_req, 0, {tag, " before sync"});
        @(negedge clk);
        check(pin_rst_req, 1, {tag, " follows pin"});
        pin_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pin_rst_req, 0, {tag, " follows release"});
    endtask

    task automatic t_bus_filter(input int cnt);
        go_idle();
        wr(3'd5, 8'(cnt));
        wr(3'd4, 8'h01);
        pin_n = 1'b0;
        repeat (cnt + 2) @(negedge clk);
        check(pin_rst_req, 0, "R4 one edge early");
        @(negedge clk);
        check(pin_rst_req, 1, "R4 assert at count+3");
        pin_n = 1'b1;
        repeat (cnt + 2) @(negedge clk);
        check(pin_rst_req, 1, "R4 release one edge early");
        @(negedge clk);
        check(pin_rst_req, 0, "R4 release at count+3");
    endtask

    task automatic t_glitch();
        int seen;
        go_idle();
        wr(3'd5, 8'd3);
        wr(3'd4, 8'h01);
        seen = 0;
        pin_n = 1'b0;
        repeat (3) @(negedge clk);
        pin_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pin_rst_req) seen = 1;
        end
        check(seen, 0, "R5 short low pulse rejected");
        pin_n = 1'b0;
        repeat (2) @(negedge clk);
        pin_n = 1'b1;
        @(negedge clk);
        pin_n = 1'b0;
        repeat (4) @(negedge clk);
        check(pin_rst_req, 0, "R5 opposite sample restarts count");
        @(negedge clk);
        check(pin_rst_req, 0, "R5 restarted count still short");
        repeat (2) @(negedge clk);
        check(pin_rst_req, 1, "R5 full length accepted");
    endtask

    task automatic t_lp_filter();
        go_idle();
        wr(3'd4, 8'h02);
        pin_n = 1'b0;
        repeat (20) @(negedge clk);
        check(pin_rst_req, 0, "R6 no ticks no change");
        tick();
        @(negedge clk);
        tick();
        check(pin_rst_req, 0, "R6 two ticks not enough");
        tick();
        check(pin_rst_req, 1, "R6 third tick accepts");
    endtask

    task automatic t_stop();
        go_idle();
        wr(3'd5, 8'd10);
        wr(3'd4, 8'h01);
        stop_mode = 1'b1;
        @(negedge clk);
        pin_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pin_rst_req, 1, "R7 stop select 0 bypasses bus filter");
        pin_n = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd4, 8'h05);
        pin_n = 1'b0;
        repeat (15) @(negedge clk);
        check(pin_rst_req, 0, "R7 stop select 1 waits for ticks");
        tick(); tick();
        check(pin_rst_req, 0, "R7 two ticks in stop");
        tick();
        check(pin_rst_req, 1, "R7 three ticks in stop");
    endtask

    task automatic t_bus_clear();
        go_idle();
        wr(3'd5, 8'd7);
        wr(3'd4, 8'h01);
        pin_n = 1'b0;
        repeat (7) @(negedge clk);
        wr(3'd4, 8'h00);
        check(pin_rst_req, 1, "R8 passthrough while deselected");
        repeat (3) @(negedge clk);
        wr(3'd4, 8'h01);
        check(pin_rst_req, 0, "R8 reselected filter starts idle");
        repeat (7) @(negedge clk);
        check(pin_rst_req, 0, "R8 count restarted from zero");
        @(negedge clk);
        check(pin_rst_req, 1, "R8 full count after reselect");
    endtask

    task automatic t_lls_clear();
        go_idle();
        wr(3'd4, 8'h06);
        stop_mode = 1'b1;
        pin_n = 1'b0;
        repeat (3) @(negedge clk);
        tick(); tick();
        lls_mode = 1'b1;
        @(negedge clk);
        tick(); tick();
        check(pin_rst_req, 0, "R9 ticks before entry discarded");
        tick();
        check(pin_rst_req, 1, "R9 three ticks after entry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reg_map();
        t_passthrough(8'h00, "R3 code 00");
        t_passthrough(8'h03, "R3 code 11");
        t_bus_filter(0);
        t_bus_filter(4);
        t_bus_filter(31);
        t_glitch();
        t_lp_filter();
        t_stop();
        t_bus_clear();
        t_lls_clear();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule